// File: doc/BRIEF.md
# Issue-Queue Entry Allocator for a Multithreaded Core

This block keeps the books for a shared issue queue in a core that runs up to four hardware threads. It does not store instructions. It holds two values for each thread: a cap, which is the largest number of queue entries the thread may occupy, and an occupancy count. It also keeps one pool-wide free count. Dispatch raises an allocate request tagged with a thread number. The block grants the request in the same cycle when both the pool and that thread still have room. Issue or squash logic returns entries through a release request, which is also tagged with a thread number.

Caps follow a sharing policy that software programs at run time. Under the shared-pool policy every thread may take the whole queue. Under the even-split policy the queue is divided equally among the threads. Under the percentage policy each thread is limited to a programmed fraction of the queue. When the set of active threads changes, the block recomputes the caps so that threads that are still running get back the room that idle threads leave unused. The division by the number of active threads reads from a small table of quotients fixed at elaboration, so no divider is built.

Top module: `iq_share_alloc`

## Requirements
- R1: While `rstN` is low and after it rises, every thread's occupancy is zero, `globalFree` equals NUM_ENTRIES, every thread's cap is NUM_ENTRIES, and `queueFull` is low. For the purpose of detecting active-set changes, the active mask last seen is taken to be all ones.
- R2: A policy load with `policySel` 0 (shared pool) or 3 (treated the same way) sets every thread's cap to NUM_ENTRIES. A single thread can then take every entry.
- R3: A policy load with `policySel` 1 (even split) sets every thread's cap to floor(NUM_ENTRIES / NUM_THREADS), whatever the active mask is.
- R4: A policy load with `policySel` 2 (percentage) sets every thread's cap to floor(min(`thresholdPct`,100) × NUM_ENTRIES / 100). This value is computed only at the load.
- R5: Under the even-split policy, a clock edge at which `activeMask` differs from its value at the previous edge sets each active thread's cap to floor(NUM_ENTRIES / number of active threads). Inactive threads keep their caps. A change to an all-zero mask changes no cap.
- R6: Under the percentage policy, an active-set change that leaves exactly one thread active raises that thread's cap to NUM_ENTRIES. Every other change leaves all caps as they are.
- R7: Under the shared-pool policy, changes to the active mask never alter any cap. When a policy load and a mask change fall on the same edge, the load wins and the mask change causes no recomputation.
- R8: A thread's `freePerThread` field (bits [t*CW +: CW], with CW = clog2(NUM_ENTRIES+1)) equals its cap minus its occupancy, or zero when the occupancy exceeds the cap.
- R9: `queueFull` is high exactly when `globalFree` is zero.
- R10: `allocGrant` is high in the same cycle as `allocValid` only when `globalFree` is nonzero and the requesting thread's free field is nonzero. A grant increments that thread's occupancy and decrements `globalFree` at the next edge.
- R11: A release for a thread with nonzero occupancy decrements that occupancy and increments `globalFree`. A release for a thread with zero occupancy is ignored. A granted allocate and an accepted release in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| policyLoad | input | 1 | Strobe that programs the policy and reloads all caps |
| policySel | input | 2 | 0 shared pool, 1 even split, 2 percentage, 3 shared pool |
| thresholdPct | input | 7 | Percentage used by policy 2 (values above 100 clamp to 100) |
| activeMask | input | NUM_THREADS | One bit per thread that is currently running |
| allocValid | input | 1 | Allocate request |
| allocTid | input | TW | Thread number of the allocate request |
| relValid | input | 1 | Release request |
| relTid | input | TW | Thread number of the release request |
| allocGrant | output | 1 | Allocate request accepted this cycle |
| freePerThread | output | NUM_THREADS*CW | Free entries for each thread, packed |
| globalFree | output | CW | Free entries in the whole pool |
| queueFull | output | 1 | Pool has no free entry |

## Verification
The bench builds the block with 16 entries and four threads. At these sizes every quotient in the lookup is distinct (16, 8, 5, 4), and 16/3 exercises the floor. A 30 % threshold truncates 4.8 down to 4. A thread can be driven above its cap when a recomputation shrinks that cap, so the zero clamp on the free count gets exercised. The pool can be filled to empty by one thread in 16 cycles, which puts the full flag and the refusal of a further allocate within a short directed run. A random phase then mixes policy loads, mask changes and simultaneous allocate and release traffic.

// File: rtl/iq_share_pkg.sv
package iq_share_pkg;

  typedef enum logic [1:0] {
    POL_DYNAMIC   = 2'd0,
    POL_PARTITION = 2'd1,
    POL_THRESHOLD = 2'd2,
    POL_SPARE     = 2'd3
  } policy_e;

  // Strobes from the control module to the datapath, one cycle wide.
  typedef struct packed {
    logic loadFull;     // every cap to the whole pool
    logic loadSplit;    // every cap to pool / thread count
    logic loadPct;      // every cap to the percentage value
    logic splitActive;  // active caps to pool / active count
    logic soloRaise;    // the single active thread to the whole pool
  } capStrobe_t;

endpackage

// File: rtl/iq_share_ctrl.sv
module iq_share_ctrl
  import iq_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int AW = $clog2(NUM_THREADS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   policyLoad,
  input  logic [1:0]             policySel,
  input  logic [NUM_THREADS-1:0] activeMask,
  output capStrobe_t             strobe,
  output logic [AW-1:0]          activeCnt
);

  policy_e                policyQ;
  logic [NUM_THREADS-1:0] prevMask;
  policy_e                selE;
  logic                   maskMoved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      policyQ  <= POL_DYNAMIC;
      prevMask <= '1;
    end else begin
      if (policyLoad) policyQ <= policy_e'(policySel);
      prevMask <= activeMask;
    end
  end

  always_comb begin
    selE      = policy_e'(policySel);
    activeCnt = AW'($countones(activeMask));
    maskMoved = (activeMask != prevMask);

    strobe.loadFull    = policyLoad && (selE == POL_DYNAMIC || selE == POL_SPARE);
    strobe.loadSplit   = policyLoad && (selE == POL_PARTITION);
    strobe.loadPct     = policyLoad && (selE == POL_THRESHOLD);
    strobe.splitActive = !policyLoad && maskMoved && (policyQ == POL_PARTITION)
                         && (activeCnt != '0);
    strobe.soloRaise   = !policyLoad && maskMoved && (policyQ == POL_THRESHOLD)
                         && (activeCnt == AW'(1));
  end

endmodule

// File: rtl/iq_share_dp.sv
module iq_share_dp
  import iq_share_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_THREADS = 4,
  localparam int CW = $clog2(NUM_ENTRIES + 1),
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int AW = $clog2(NUM_THREADS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  capStrobe_t                strobe,
  input  logic [AW-1:0]             activeCnt,
  input  logic [NUM_THREADS-1:0]    activeMask,
  input  logic [6:0]                thresholdPct,
  input  logic                      allocValid,
  input  logic [TW-1:0]             allocTid,
  input  logic                      relValid,
  input  logic [TW-1:0]             relTid,
  output logic                      allocGrant,
  output logic [NUM_THREADS*CW-1:0] freePerThread,
  output logic [CW-1:0]             globalFree,
  output logic                      queueFull
);

  localparam int PW = $clog2(100 * NUM_ENTRIES + 1);
  localparam logic [CW-1:0] FULL_CAP  = CW'(NUM_ENTRIES);
  localparam logic [CW-1:0] START_CAP = CW'(NUM_ENTRIES / NUM_THREADS);

  logic [CW-1:0] quotTab [NUM_THREADS+1];
  logic [CW-1:0] freeW   [NUM_THREADS];
  logic [CW-1:0] occW    [NUM_THREADS];
  logic [CW-1:0] globalFreeQ, splitQuot, pctCap, selFree;
  logic [6:0]    pctClamp;
  logic [PW-1:0] pctProd;
  logic          allocTidOk, relTidOk, relOk;

  // Quotients of the pool size by each possible active count.
  for (genvar q = 0; q <= NUM_THREADS; q++) begin : g_quot
    if (q == 0) begin : g_zero
      assign quotTab[q] = '0;
    end else begin : g_div
      assign quotTab[q] = CW'(NUM_ENTRIES / q);
    end
  end

  always_comb begin
    splitQuot  = quotTab[activeCnt];
    pctClamp   = (thresholdPct > 7'd100) ? 7'd100 : thresholdPct;
    pctProd    = PW'(pctClamp) * PW'(NUM_ENTRIES);
    pctCap     = CW'(pctProd / PW'(100));
    allocTidOk = ({1'b0, allocTid} < (TW + 1)'(NUM_THREADS));
    relTidOk   = ({1'b0, relTid} < (TW + 1)'(NUM_THREADS));
    selFree    = allocTidOk ? freeW[allocTid] : '0;
    allocGrant = allocValid && allocTidOk && (globalFreeQ != '0) && (selFree != '0);
    relOk      = relValid && relTidOk && (occW[relTid] != '0);
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CW-1:0] capQ, occQ;
    logic          incT, decT;

    assign incT = allocGrant && (allocTid == TW'(t));
    assign decT = relOk && (relTid == TW'(t));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 capQ <= FULL_CAP;
      else if (strobe.loadFull)                  capQ <= FULL_CAP;
      else if (strobe.loadSplit)                 capQ <= START_CAP;
      else if (strobe.loadPct)                   capQ <= pctCap;
      else if (strobe.splitActive && activeMask[t]) capQ <= splitQuot;
      else if (strobe.soloRaise && activeMask[t])   capQ <= FULL_CAP;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              occQ <= '0;
      else if (incT && !decT) occQ <= occQ + CW'(1);
      else if (decT && !incT) occQ <= occQ - CW'(1);
    end

    assign occW[t]  = occQ;
    assign freeW[t] = (capQ > occQ) ? (capQ - occQ) : '0;
    assign freePerThread[t*CW +: CW] = freeW[t];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     globalFreeQ <= FULL_CAP;
    else if (allocGrant && !relOk) globalFreeQ <= globalFreeQ - CW'(1);
    else if (relOk && !allocGrant) globalFreeQ <= globalFreeQ + CW'(1);
  end

  assign globalFree = globalFreeQ;
  assign queueFull  = (globalFreeQ == '0);

endmodule

// File: rtl/iq_share_alloc.sv
module iq_share_alloc
  import iq_share_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_THREADS = 4,
  localparam int CW = $clog2(NUM_ENTRIES + 1),
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int AW = $clog2(NUM_THREADS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      policyLoad,
  input  logic [1:0]                policySel,
  input  logic [6:0]                thresholdPct,
  input  logic [NUM_THREADS-1:0]    activeMask,
  input  logic                      allocValid,
  input  logic [TW-1:0]             allocTid,
  input  logic                      relValid,
  input  logic [TW-1:0]             relTid,
  output logic                      allocGrant,
  output logic [NUM_THREADS*CW-1:0] freePerThread,
  output logic [CW-1:0]             globalFree,
  output logic                      queueFull
);

  capStrobe_t    strobe;
  logic [AW-1:0] activeCnt;

  iq_share_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .policyLoad (policyLoad),
    .policySel  (policySel),
    .activeMask (activeMask),
    .strobe     (strobe),
    .activeCnt  (activeCnt)
  );

  iq_share_dp #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .activeCnt     (activeCnt),
    .activeMask    (activeMask),
    .thresholdPct  (thresholdPct),
    .allocValid    (allocValid),
    .allocTid      (allocTid),
    .relValid      (relValid),
    .relTid        (relTid),
    .allocGrant    (allocGrant),
    .freePerThread (freePerThread),
    .globalFree    (globalFree),
    .queueFull     (queueFull)
  );

endmodule

// File: rtl/iq_share_alloc_chk.sv
module iq_share_alloc_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_THREADS = 4,
  localparam int CW = $clog2(NUM_ENTRIES + 1),
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      allocValid,
  input logic [TW-1:0]             allocTid,
  input logic                      relValid,
  input logic                      allocGrant,
  input logic [NUM_THREADS*CW-1:0] freePerThread,
  input logic [CW-1:0]             globalFree,
  input logic                      queueFull
);

  // R9 / R10: a full pool never grants
  p_no_grant_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    queueFull |-> !allocGrant);

  // R10: a grant needs a request and room in the requesting thread
  p_grant_room_r10: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> (allocValid && freePerThread[allocTid*CW +: CW] != '0));

  // R10: a grant with no release takes exactly one entry from the pool
  p_grant_takes_one_r10: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant && !relValid) |=> (globalFree == $past(globalFree) - CW'(1)));

  // R11: with no traffic the pool count holds
  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!allocValid && !relValid) |=> $stable(globalFree));

  // R1 / R11: the pool count never exceeds its size
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    globalFree <= CW'(NUM_ENTRIES));

endmodule

bind iq_share_alloc iq_share_alloc_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .allocValid    (allocValid),
  .allocTid      (allocTid),
  .relValid      (relValid),
  .allocGrant    (allocGrant),
  .freePerThread (freePerThread),
  .globalFree    (globalFree),
  .queueFull     (queueFull)
);

// File: tb/iq_share_alloc_tb.sv
`timescale 1ns/1ps
module iq_share_alloc_tb;

  localparam int NE = 16;
  localparam int NT = 4;
  localparam int CW = 5;
  localparam int TW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN, policyLoad, allocValid, relValid;
  logic [1:0]       policySel;
  logic [6:0]       thresholdPct;
  logic [NT-1:0]    activeMask;
  logic [TW-1:0]    allocTid, relTid;
  logic             allocGrant, queueFull;
  logic [NT*CW-1:0] freePerThread;
  logic [CW-1:0]    globalFree;

  iq_share_alloc #(.NUM_ENTRIES(NE), .NUM_THREADS(NT)) u_dut (
    .clk(clk), .rstN(rstN), .policyLoad(policyLoad), .policySel(policySel),
    .thresholdPct(thresholdPct), .activeMask(activeMask),
    .allocValid(allocValid), .allocTid(allocTid),
    .relValid(relValid), .relTid(relTid),
    .allocGrant(allocGrant), .freePerThread(freePerThread),
    .globalFree(globalFree), .queueFull(queueFull)
  );

  // Behavioural reference state
  int capM [NT];
  int occM [NT];
  int gfreeM, polM;
  logic [NT-1:0] prevM;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  function automatic int freeOf(int t);
    return (capM[t] > occM[t]) ? capM[t] - occM[t] : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expGrant();
    return allocValid && gfreeM > 0 && freeOf(int'(allocTid)) > 0;
  endfunction

  task automatic compareAll(string req);
    check(req, "allocGrant", int'(allocGrant), int'(expGrant()));
    check(req, "globalFree", int'(globalFree), gfreeM);
    check(req, "queueFull", int'(queueFull), int'(gfreeM == 0));
    for (int t = 0; t < NT; t++)
      check(req, $sformatf("free[%0d]", t), int'(freePerThread[t*CW +: CW]), freeOf(t));
  endtask

  task automatic step(string req);
    bit g, r;
    int p, pc;
    #1 compareAll(req);
    g = expGrant();
    r = relValid && occM[int'(relTid)] > 0;
    @(posedge clk);
    if (policyLoad) begin
      polM = int'(policySel);
      pc = (thresholdPct > 100) ? 100 : int'(thresholdPct);
      for (int t = 0; t < NT; t++)
        capM[t] = (polM == 1) ? NE / NT : (polM == 2) ? (pc * NE) / 100 : NE;
    end else if (activeMask != prevM) begin
      p = $countones(activeMask);
      for (int t = 0; t < NT; t++) begin
        if (activeMask[t] && polM == 1 && p != 0) capM[t] = NE / p;
        if (activeMask[t] && polM == 2 && p == 1) capM[t] = NE;
      end
    end
    prevM = activeMask;
    if (g) begin occM[int'(allocTid)]++; gfreeM--; end
    if (r) begin occM[int'(relTid)]--;   gfreeM++; end
    @(negedge clk);
  endtask

  task automatic idle();
    policyLoad = 1'b0; allocValid = 1'b0; relValid = 1'b0;
  endtask

  task automatic doAlloc(int t, string req);
    allocValid = 1'b1; allocTid = TW'(t); step(req); idle();
  endtask

  task automatic doRel(int t, string req);
    relValid = 1'b1; relTid = TW'(t); step(req); idle();
  endtask

  task automatic loadPol(int sel, int pct, string req);
    policyLoad = 1'b1; policySel = 2'(sel); thresholdPct = 7'(pct);
    step(req); idle();
  endtask

  task automatic setMask(logic [NT-1:0] m, string req);
    activeMask = m; step(req);
  endtask

  task automatic drainAll(string req);
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < NE + 1; k++) doRel(t, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; idle();
    policySel = 2'd0; thresholdPct = 7'd0; activeMask = '1;
    allocTid = '0; relTid = '0;
    for (int t = 0; t < NT; t++) begin capM[t] = NE; occM[t] = 0; end
    gfreeM = NE; polM = 0; prevM = '1;
    repeat (2) @(negedge clk);
    #1 compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    step("R1");

    // Shared pool: one thread takes all, then refused
    for (int k = 0; k < NE; k++) doAlloc(0, "R2");
    doAlloc(0, "R9");
    doAlloc(1, "R10");
    // simultaneous allocate and release from different threads
    doRel(0, "R11");
    allocValid = 1'b1; allocTid = 2'd1; relValid = 1'b1; relTid = 2'd0;
    step("R11"); idle();
    // release on an empty thread is ignored
    doRel(2, "R11");
    step("R11");
    drainAll("R11");

    // Mask change under the shared pool changes nothing
    setMask(4'b0001, "R7");
    setMask(4'b1111, "R7");

    // Even split
    loadPol(1, 0, "R3");
    for (int k = 0; k < 5; k++) doAlloc(1, "R3");
    setMask(4'b0011, "R5");
    doAlloc(1, "R5");
    setMask(4'b0111, "R5");
    step("R5");
    setMask(4'b1111, "R8");
    step("R8");
    setMask(4'b0000, "R5");
    setMask(4'b0001, "R5");
    // load wins over a same-edge mask change
    activeMask = 4'b0110; loadPol(1, 0, "R7");
    step("R7");
    drainAll("R8");

    // Percentage
    loadPol(2, 30, "R4");
    for (int k = 0; k < 6; k++) doAlloc(3, "R4");
    setMask(4'b0100, "R6");
    setMask(4'b0101, "R6");
    setMask(4'b1000, "R6");
    for (int k = 0; k < 6; k++) doAlloc(3, "R6");
    loadPol(2, 120, "R4");
    loadPol(2, 0, "R4");
    doAlloc(0, "R4");
    loadPol(3, 0, "R2");
    drainAll("R2");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      policyLoad   = ($urandom % 20) == 0;
      policySel    = 2'($urandom);
      thresholdPct = 7'($urandom);
      if (($urandom % 6) == 0) activeMask = NT'($urandom);
      allocValid   = 1'($urandom);
      allocTid     = TW'($urandom);
      relValid     = ($urandom % 3) == 0;
      relTid       = TW'($urandom);
      step("R10");
    end
    idle();
    step("R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule